// File: doc/BRIEF.md
# Patchable Microcode Store

This block holds the microprogram of a processor. It serves one microword for each microaddress from a fixed read-only array, and it lets a small writable array take the place of chosen words without any change to the fixed contents. A 14-bit microaddress goes in, and one clock edge later a 40-bit microword comes out, together with an even-parity bit.

The word is assembled from five identical byte-wide slices. Each slice holds its own byte of the read-only contents (16K entries), a 1K-entry byte-wide patch memory, a 32-entry match table of 14-bit tags with valid bits, and a patch-offset register. Every cycle, each slice compares the microaddress against its match table while the fixed array is read. On a hit, the slice returns its patch byte in place of the fixed byte. The patch location is the hit index plus the offset, modulo 1024.

One load port fills all five slices at once. A 40-bit load datum supplies byte s to slice s. A 2-bit kind field selects what is written: a patch memory word, a match entry set, a match entry clear, or the patch offset.

Top module: `ucs_store`

## Requirements
- R1: A microaddress on `uaddr` before a rising edge produces its microword on `uword` after that edge. A new address may be presented every cycle. Byte s of an unpatched word (bits 8s+7..8s) equals `uaddr[7:0] ^ {uaddr[13:8],2'b00} ^ (8'h11*s)`.
- R2: While `rst_n` is low at a rising edge, `uword` and `uparity` become 0, every match entry becomes invalid, and the patch offset becomes 0. After reset, every read returns the fixed contents until a match entry is set.
- R3: When a valid match entry k holds a tag equal to the microaddress, `uword` is the patch word at location (offset + k) mod 1024 instead of the fixed word. Addresses that do not match are served from the fixed array.
- R4: When several valid entries match the same microaddress, the entry with the lowest index selects the patch word.
- R5: A cleared match entry no longer redirects. A higher-numbered entry with the same tag then takes effect, or the fixed word returns if there is none.
- R6: `uparity` makes the total number of ones in {`uparity`,`uword`} even.
- R7: The patch offset moves the patch location for every entry, and the sum wraps around at 1024.
- R8: Writing a patch memory word that no valid match entry points to does not change `uword` for any address.
- R9: A load is taken at a rising edge when `ld_en` is high. `ld_kind` 2'b00 writes `ld_data` to patch location `ld_index`. 2'b01 sets entry `ld_index[4:0]` valid with tag `ld_tag`. 2'b10 clears entry `ld_index[4:0]`. 2'b11 loads the offset from `ld_index`. The load affects reads that are sampled at later edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| uaddr | input | 14 | Microaddress to look up |
| ld_en | input | 1 | Load strobe |
| ld_kind | input | 2 | Load kind: patch word, set entry, clear entry, offset |
| ld_index | input | 10 | Patch location, entry index (low 5 bits), or offset value |
| ld_tag | input | 14 | Tag for a match entry set |
| ld_data | input | 40 | Patch word; byte s goes to slice s |
| uword | output | 40 | Registered microword |
| uparity | output | 1 | Even parity over `uword` |

## Verification
Plain reads at the address extremes and at mixed bit patterns confirm the fixed contents and the one-cycle latency. Back-to-back alternation of patched and unpatched addresses shows whether the redirect is made per cycle rather than held over from the previous cycle. Two entries that share a tag, followed by clears in turn, distinguish lowest-index priority from last-written or highest-index selection. A large offset combined with the top entry index checks that the patch location wraps. A patch write with no pointing entry shows that the patch memory leaks nothing on its own.

// File: rtl/ucs_pkg.sv
// Package: shared sizes, load-kind encoding and the fixed-contents function
// of the patchable microcode store. Assumes a 40-bit word made of 8-bit slices.
package ucs_pkg;

    localparam int UADDR_W    = 14;
    localparam int SLICE_W    = 8;
    localparam int NUM_SLICES = 5;
    localparam int WORD_W     = SLICE_W * NUM_SLICES;
    localparam int CAM_DEPTH  = 32;
    localparam int CAM_IDX_W  = $clog2(CAM_DEPTH);
    localparam int PATCH_DEPTH = 1024;
    localparam int PATCH_AW   = $clog2(PATCH_DEPTH);

    typedef enum logic [1:0] {
        LD_PATCH   = 2'b00,
        LD_CAM_SET = 2'b01,
        LD_CAM_CLR = 2'b10,
        LD_OFFSET  = 2'b11
    } ld_kind_e;

    // Fixed microcode byte for slice s at address a (computed, not tabulated).
    function automatic logic [SLICE_W-1:0] rom_byte(input logic [UADDR_W-1:0] a,
                                                     input int unsigned s);
        logic [SLICE_W-1:0] k;
        k = SLICE_W'(s * 17);
        return a[7:0] ^ {a[13:8], 2'b00} ^ k;
    endfunction

endpackage

// File: rtl/ucs_cam.sv
// Module: match table of tagged entries. Compares the lookup address with
// every valid tag in parallel and reports the lowest matching index.
// Assumes at most one load command per cycle; set has priority over clear.
module ucs_cam #(
    parameter int ADDR_W = 14,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_tag,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);

    logic [DEPTH-1:0]  valid_q;
    logic [ADDR_W-1:0] tag_q [DEPTH];
    logic [DEPTH-1:0]  match;

    // Entry state: reset invalidates all, loads set or clear one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_set) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= wr_tag;
        end else if (wr_clr) begin
            valid_q[wr_idx] <= 1'b0;
        end
    end

    // Per-entry comparators.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = valid_q[i] && (tag_q[i] == lk_addr);
    end

    // Priority encoder: the lowest matching index wins.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // R2: leaving reset, no entry is valid.
    a_r2_cam_empty: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (valid_q == '0));

    // R4: the reported index is a matching entry with no lower one matching.
    a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (match[hit_idx] && ((match & ((DEPTH'(1) << hit_idx) - DEPTH'(1))) == '0)));

    // R9: a set makes the entry valid with the given tag at the next edge.
    a_r9_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));

    // R5: a clear alone leaves the entry invalid.
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !wr_set) |=> !valid_q[$past(wr_idx)]);

endmodule

// File: rtl/ucs_patch_ram.sv
// Module: byte-wide patch memory with one synchronous write port and one
// combinational read port. Contents are not reset; only written locations
// are meaningful.
module ucs_patch_ram #(
    parameter int AW = 10,
    parameter int W  = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read port.
    assign rdata = mem[raddr];

endmodule

// File: rtl/ucs_slice.sv
// Module: one byte slice of the store. Holds its fixed byte function, its
// own match table, patch memory and offset register, and returns the
// selected byte with its parity. All slices receive the same load commands.
module ucs_slice
    import ucs_pkg::*;
#(
    parameter int SLICE_IDX = 0,
    parameter int ADDR_W    = UADDR_W,
    parameter int W         = SLICE_W,
    parameter int DEPTH     = CAM_DEPTH,
    parameter int PAW       = PATCH_AW,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] uaddr,
    input  logic              ld_en,
    input  logic [1:0]        ld_kind,
    input  logic [PAW-1:0]    ld_index,
    input  logic [ADDR_W-1:0] ld_tag,
    input  logic [W-1:0]      ld_byte,
    output logic [W-1:0]      out_byte,
    output logic              out_par,
    output logic              out_hit
);

    logic [PAW-1:0]   offset_q;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [PAW-1:0]   patch_loc;
    logic [W-1:0]     patch_byte;
    logic [W-1:0]     fixed_byte;
    logic             wr_set, wr_clr, wr_patch, wr_off;

    // Load-kind decode.
    always_comb begin
        wr_patch = ld_en && (ld_kind == LD_PATCH);
        wr_set   = ld_en && (ld_kind == LD_CAM_SET);
        wr_clr   = ld_en && (ld_kind == LD_CAM_CLR);
        wr_off   = ld_en && (ld_kind == LD_OFFSET);
    end

    // Offset register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      offset_q <= '0;
        else if (wr_off) offset_q <= ld_index;
    end

    ucs_cam #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_cam (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_addr (uaddr),
        .wr_set  (wr_set),
        .wr_clr  (wr_clr),
        .wr_idx  (ld_index[IDX_W-1:0]),
        .wr_tag  (ld_tag),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    // Patch location: hit index plus offset, wrapping at the memory size.
    assign patch_loc = offset_q + PAW'(hit_idx);

    ucs_patch_ram #(.AW(PAW), .W(W)) u_ram (
        .clk   (clk),
        .we    (wr_patch),
        .waddr (ld_index),
        .wdata (ld_byte),
        .raddr (patch_loc),
        .rdata (patch_byte)
    );

    // Fixed contents for this slice.
    assign fixed_byte = rom_byte(uaddr, SLICE_IDX);

    // Output select and slice parity.
    always_comb begin
        out_byte = hit ? patch_byte : fixed_byte;
        out_par  = ^out_byte;
        out_hit  = hit;
    end

    // R9: an offset load is visible at the next edge.
    a_r9_offset_takes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_off |=> (offset_q == $past(ld_index)));

endmodule

// File: rtl/ucs_store.sv
// Module: top of the patchable microcode store. Five byte slices are looked
// up in parallel; their bytes and parities are registered into the 40-bit
// microword and its even-parity bit. One cycle of read latency.
module ucs_store
    import ucs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [UADDR_W-1:0] uaddr,
    input  logic               ld_en,
    input  logic [1:0]         ld_kind,
    input  logic [PATCH_AW-1:0] ld_index,
    input  logic [UADDR_W-1:0] ld_tag,
    input  logic [WORD_W-1:0]  ld_data,
    output logic [WORD_W-1:0]  uword,
    output logic               uparity
);

    logic [WORD_W-1:0]     word_next;
    logic [NUM_SLICES-1:0] slice_par;
    logic [NUM_SLICES-1:0] slice_hit;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        ucs_slice #(.SLICE_IDX(s)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .uaddr    (uaddr),
            .ld_en    (ld_en),
            .ld_kind  (ld_kind),
            .ld_index (ld_index),
            .ld_tag   (ld_tag),
            .ld_byte  (ld_data[s*SLICE_W +: SLICE_W]),
            .out_byte (word_next[s*SLICE_W +: SLICE_W]),
            .out_par  (slice_par[s]),
            .out_hit  (slice_hit[s])
        );
    end

    // Output register: word and parity combined from the slice parities.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uword   <= '0;
            uparity <= 1'b0;
        end else begin
            uword   <= word_next;
            uparity <= ^slice_par;
        end
    end

    // R6: the parity from the slice parities matches the registered word.
    a_r6_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (^{uparity, uword}) == 1'b0);

    // R3: all slices see the same table, so they redirect together.
    a_r3_slices_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_hit == '0) || (slice_hit == '1));

endmodule

// File: tb/ucs_store_bench.sv
`timescale 1ns/100ps
module ucs_store_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] uaddr = '0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_kind = '0;
    logic [9:0]  ld_index = '0;
    logic [13:0] ld_tag = '0;
    logic [39:0] ld_data = '0;
    logic [39:0] uword;
    logic        uparity;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Reference model state.
    logic        m_valid [32];
    logic [13:0] m_tag   [32];
    logic [39:0] m_ram   [1024];
    logic [9:0]  m_off;

    // Scoreboard queues.
    logic [39:0] q_word [$];
    string       q_req  [$];
    int          q_due  [$];

    ucs_store u_ucs_store (
        .clk(clk), .rst_n(rst_n), .uaddr(uaddr), .ld_en(ld_en),
        .ld_kind(ld_kind), .ld_index(ld_index), .ld_tag(ld_tag),
        .ld_data(ld_data), .uword(uword), .uparity(uparity)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [39:0] fixed_word(input logic [13:0] a);
        logic [39:0] w;
        for (int s = 0; s < 5; s++)
            w[s*8 +: 8] = a[7:0] ^ {a[13:8], 2'b00} ^ 8'(s * 17);
        return w;
    endfunction

    function automatic logic [39:0] model_word(input logic [13:0] a);
        for (int i = 0; i < 32; i++)
            if (m_valid[i] && m_tag[i] == a) return m_ram[10'(m_off + 10'(i))];
        return fixed_word(a);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: present one address and queue the expected word.
    task automatic rd(input logic [13:0] a, input string req);
        @(negedge clk);
        uaddr = a;
        q_word.push_back(model_word(a));
        q_req.push_back(req);
        q_due.push_back(cyc + 1);
    endtask

    // Load port driver, with model update.
    task automatic load(input logic [1:0] k, input logic [9:0] idx,
                        input logic [13:0] t, input logic [39:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_kind = k; ld_index = idx; ld_tag = t; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        case (k)
            2'b00: m_ram[idx] = d;
            2'b01: begin m_valid[idx[4:0]] = 1'b1; m_tag[idx[4:0]] = t; end
            2'b10: m_valid[idx[4:0]] = 1'b0;
            default: m_off = idx;
        endcase
    endtask

    // Monitor: compare word and parity when each read falls due.
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] == cyc) begin
            logic [39:0] w;
            string r;
            w = q_word.pop_front();
            r = q_req.pop_front();
            void'(q_due.pop_front());
            check(r, 64'(uword), 64'(w));
            check("R6 parity", 64'(uparity), 64'(^w));
        end
    end

    // Watchdog.
    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m_valid[i] = 1'b0;
        m_off = '0;
        repeat (3) @(negedge clk);
        check("R2 reset word", 64'(uword), 64'd0);
        check("R2 reset parity", 64'(uparity), 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1/R2: fixed contents, back to back.
        rd(14'h0000, "R1 fixed 0000");
        rd(14'h3FFF, "R1 fixed 3FFF");
        rd(14'h1234, "R2 fixed 1234");
        rd(14'h2AAA, "R1 fixed 2AAA");

        // R8: patch word with no pointing entry.
        load(2'b00, 10'd0, '0, 40'hDEAD_BEEF_01);
        rd(14'h1234, "R8 unpointed patch");
        rd(14'h0000, "R8 unpointed patch 0");

        // R3/R9: set entry 0 and alternate patched/unpatched addresses.
        load(2'b01, 10'd0, 14'h1234, '0);
        rd(14'h1234, "R3 patched hit");
        rd(14'h1235, "R3 miss neighbour");
        rd(14'h1234, "R1 alternate hit");
        rd(14'h2AAA, "R1 alternate miss");

        // R4/R5: two entries with the same tag.
        load(2'b00, 10'd3, '0, 40'h33_3333_3333);
        load(2'b00, 10'd7, '0, 40'h77_7070_0707);
        load(2'b01, 10'd7, 14'h0ABC, '0);
        load(2'b01, 10'd3, 14'h0ABC, '0);
        rd(14'h0ABC, "R4 lowest index");
        load(2'b10, 10'd3, '0, '0);
        rd(14'h0ABC, "R5 clear low entry");
        load(2'b10, 10'd7, '0, '0);
        rd(14'h0ABC, "R5 clear last entry");

        // R7/R9: offset with wrap around.
        load(2'b00, 10'd7, '0, 40'hA5_5A0F_F001);
        load(2'b00, 10'd1000, '0, 40'h12_3456_789A);
        load(2'b11, 10'd1000, '0, '0);
        load(2'b01, 10'd31, 14'h3FFF, '0);
        rd(14'h3FFF, "R7 wrapped location");
        rd(14'h1234, "R9 offset moved entry 0");
        rd(14'h0001, "R7 miss under offset");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule